// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block is a small queue of prefetched cache lines placed next to a first-level cache. A cache miss that is not already covered by the queue restarts it. The queue then holds the lines that follow the missing one, and the block asks memory for each of them in turn. Prefetched data stays in the queue and is never written into the cache array on its own. The cache therefore sees a line only when a later miss actually asks for it.

Every lookup the cache makes is presented to the block in the same cycle as the cache tag check, together with the cache's own hit or miss result. When the cache misses and the line at the head of the queue has the same address, the block supplies the data in that same cycle. It then drops the head and adds the next sequential line at the tail, so the queue stays the same length. A head match whose data has not come back yet raises a stall instead. Memory receives line addresses over a valid/ready channel. Returned lines carry their address and may arrive in any order.

Addresses on all ports are line addresses: the byte address with the offset inside the line removed.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the block holds no stream: `req_valid`, `pf_hit` and `pf_stall` are all 0, and a cache miss of any address restarts the queue.
- R2: A cache miss (`lk_valid` and `lk_miss` both 1) at line A that does not match a valid head restarts the queue with lines A+1 to A+DEPTH. These lines are requested one per cycle, in increasing order, and no further request follows until the head is consumed.
- R3: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and `req_line` stay unchanged in the next cycle, unless a restart happens in that cycle.
- R4: A cache miss at the head's line, when the head's data has returned, gives `pf_hit`=1 in the same cycle, with `pf_data` equal to the data filled for that line.
- R5: A cache miss at the head's line whose data has not yet returned gives `pf_stall`=1 and `pf_hit`=0. The queue is left unchanged, and the same lookup hits from the cycle after the fill arrives.
- R6: Each head hit appends the line one past the last line placed in the queue, and a request for that line follows.
- R7: A fill is taken by whichever queued line has the same address, whatever order the fills return in.
- R8: A fill is dropped when no queued line both has its request already accepted and is still waiting for data. This covers returns belonging to a stream that has since been replaced.
- R9: A lookup with `lk_miss`=0 has no effect: no hit, no stall, and the queue and its requests are unchanged.
- R10: Only the head is compared. A cache miss that matches any other queued line restarts the queue at that miss address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Cache lookup this cycle |
| lk_miss | input | 1 | The cache tag check missed for this lookup |
| lk_line | input | LINE_W | Line address being looked up |
| pf_hit | output | 1 | Head line supplied to the cache this cycle |
| pf_stall | output | 1 | Head matches but its data is still outstanding |
| pf_data | output | DATA_W | Head line data, valid with `pf_hit` |
| req_valid | output | 1 | Line request to memory pending |
| req_ready | input | 1 | Memory accepts the request |
| req_line | output | LINE_W | Requested line address |
| fill_valid | input | 1 | Returned line present |
| fill_line | input | LINE_W | Address of the returned line |
| fill_data | input | DATA_W | Returned line data |

## Verification
The assertions check the request channel on every cycle. Accepted requests must form one unbroken ascending run that begins at the restart address plus one. A pending request may not change while memory holds it off. Hit and stall must never occur together, and every hit must be followed by a new request. Other properties depend on what happened earlier. Data correctness, dropping of stale or unrequested fills, out-of-order returns, the stall that ends once its fill arrives, and the fact that non-head and cache-hit lookups are ignored all need the bench's scenarios and its reference model.

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES),
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_miss,
  input  logic [LINE_W-1:0] lk_line,
  output logic              pf_hit,
  output logic              pf_stall,
  output logic [DATA_W-1:0] pf_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LINE_W-1:0] req_line,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              live;
  logic [PTR_W-1:0]  hd, pick;
  logic [LINE_W-1:0] nxt;
  logic [LINE_W-1:0] ln  [DEPTH];
  logic [DATA_W-1:0] dat [DEPTH];
  logic [DEPTH-1:0]  iss, rdy, fhit;

  function automatic logic [PTR_W-1:0] slot(input logic [PTR_W-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  wire is_miss = lk_valid & lk_miss;
  wire head_eq = live & (ln[hd] == lk_line);
  wire restart = is_miss & ~head_eq;
  assign pf_hit   = is_miss & head_eq & rdy[hd];
  assign pf_stall = is_miss & head_eq & ~rdy[hd];
  assign pf_data  = dat[hd];
  assign req_line = ln[pick];

  always_comb begin
    req_valid = 1'b0;
    pick      = hd;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (live && !iss[slot(hd, k)]) begin
        req_valid = 1'b1;
        pick      = slot(hd, k);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      fhit[i] = fill_valid & live & iss[i] & ~rdy[i] & (ln[i] == fill_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0;
      hd   <= '0;
      nxt  <= '0;
      iss  <= '0;
      rdy  <= '0;
      for (int i = 0; i < DEPTH; i++) ln[i] <= '0;
    end else if (restart) begin
      live <= 1'b1;
      hd   <= '0;
      iss  <= '0;
      rdy  <= '0;
      nxt  <= lk_line + LINE_W'(DEPTH + 1);
      for (int i = 0; i < DEPTH; i++) ln[i] <= lk_line + LINE_W'(i + 1);
    end else begin
      if (req_valid && req_ready) iss[pick] <= 1'b1;
      rdy <= rdy | fhit;
      if (pf_hit) begin
        ln[hd]  <= nxt;
        iss[hd] <= 1'b0;
        rdy[hd] <= 1'b0;
        nxt     <= nxt + LINE_W'(1);
        hd      <= slot(hd, 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (fhit[i] && !restart) dat[i] <= fill_data;
  end

  logic              seq_ok;
  logic [LINE_W-1:0] last_acc;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_ok   <= 1'b0;
      last_acc <= '0;
    end else if (restart) begin
      seq_ok   <= 1'b1;
      last_acc <= lk_line;
    end else if (req_valid && req_ready) begin
      last_acc <= req_line;
    end
  end

  a_r1_quiet_until_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ok |-> !req_valid && !pf_hit && !pf_stall);
  a_r2_ascending_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && seq_ok) |-> req_line == last_acc + LINE_W'(1));
  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !restart) |=> req_valid && $stable(req_line));
  a_r5_stall_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pf_stall |-> !pf_hit);
  a_r6_hit_requests_next: assert property (@(posedge clk) disable iff (!rst_n)
    pf_hit |=> req_valid);
endmodule

// File: tb/stream_prefetch_buf_tb.sv
module stream_prefetch_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int LINE_BYTES = 64;
  localparam int ADDR_W     = 32;
  localparam int LINE_W     = ADDR_W - $clog2(LINE_BYTES);
  localparam int DATA_W     = LINE_BYTES * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_miss = 1'b0, req_ready = 1'b0, fill_valid = 1'b0;
  logic [LINE_W-1:0] lk_line = '0, fill_line = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic pf_hit, pf_stall, req_valid;
  logic [DATA_W-1:0] pf_data;
  logic [LINE_W-1:0] req_line;

  stream_prefetch_buf #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_miss(lk_miss), .lk_line(lk_line),
    .pf_hit(pf_hit), .pf_stall(pf_stall), .pf_data(pf_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [LINE_W-1:0] ml [DEPTH];
  bit mr [DEPTH], mi [DEPTH];
  bit mlive = 0;
  logic [LINE_W-1:0] mnext = '0;
  logic [LINE_W-1:0] pend [64];
  int npend = 0;

  function automatic logic [DATA_W-1:0] data_of(input logic [LINE_W-1:0] l);
    logic [DATA_W-1:0] d;
    for (int w = 0; w < DATA_W / 32; w++) d[w*32 +: 32] = (32'(l) * 32'h9E3779B1) + 32'(w);
    return d;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drop_pend(input logic [LINE_W-1:0] l);
    for (int i = 0; i < npend; i++)
      if (pend[i] == l) begin
        pend[i] = pend[npend - 1];
        npend--;
        return;
      end
  endtask

  task automatic step(input bit lv, input bit lm, input logic [LINE_W-1:0] ll,
                      input bit rr, input bit fv, input logic [LINE_W-1:0] fl);
    bit match, eh, es, rs, erv;
    int ek;
    @(negedge clk);
    lk_valid = lv; lk_miss = lm; lk_line = ll; req_ready = rr;
    fill_valid = fv; fill_line = fl; fill_data = data_of(fl);
    #1;
    match = lv && lm && mlive && (ml[0] == ll);
    eh = match && mr[0];
    es = match && !mr[0];
    rs = lv && lm && !match;
    erv = 0; ek = 0;
    if (mlive)
      for (int i = DEPTH - 1; i >= 0; i--) if (!mi[i]) begin erv = 1; ek = i; end
    chk(pf_hit == eh, "R4", "pf_hit", longint'(pf_hit), longint'(eh));
    chk(pf_stall == es, "R5", "pf_stall", longint'(pf_stall), longint'(es));
    chk(req_valid == erv, "R2", "req_valid", longint'(req_valid), longint'(erv));
    if (erv) chk(req_line == ml[ek], "R6", "req_line", longint'(req_line), longint'(ml[ek]));
    if (eh) chk(pf_data == data_of(ll), "R7", "pf_data[31:0]", longint'(pf_data[31:0]), longint'(data_of(ll)));
    if (erv && rr && npend < 64) begin pend[npend] = ml[ek]; npend++; end
    if (fv) drop_pend(fl);
    if (rs) begin
      mlive = 1;
      for (int i = 0; i < DEPTH; i++) begin ml[i] = ll + LINE_W'(i + 1); mr[i] = 0; mi[i] = 0; end
      mnext = ll + LINE_W'(DEPTH + 1);
    end else begin
      if (fv) for (int i = 0; i < DEPTH; i++) if (mlive && mi[i] && !mr[i] && ml[i] == fl) mr[i] = 1;
      if (erv && rr) mi[ek] = 1;
      if (eh) begin
        for (int i = 0; i < DEPTH - 1; i++) begin ml[i] = ml[i+1]; mr[i] = mr[i+1]; mi[i] = mi[i+1]; end
        ml[DEPTH-1] = mnext; mr[DEPTH-1] = 0; mi[DEPTH-1] = 0;
        mnext = mnext + LINE_W'(1);
      end
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [LINE_W-1:0] l;
    bit lv, lm, rr, fv;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid && !pf_hit && !pf_stall, "R1", "idle after reset",
        longint'({req_valid, pf_hit, pf_stall}), 0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 26'd50, 1, 0, 0);
    chk(!pf_hit && !pf_stall && !req_valid, "R9", "cache-hit lookup with no stream", longint'(req_valid), 0);
    step(1, 1, 26'd100, 0, 0, 0);
    chk(!pf_hit && !pf_stall, "R1", "first miss restarts", longint'(pf_hit), 0);
    step(0, 0, 0, 0, 0, 0);
    chk(req_valid && req_line == 26'd101, "R2", "first request", longint'(req_line), 101);
    step(0, 0, 0, 0, 0, 0);
    chk(req_valid && req_line == 26'd101, "R3", "request held", longint'(req_line), 101);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(req_line == 26'd102, "R2", "second request", longint'(req_line), 102);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(req_line == 26'd104, "R2", "fourth request", longint'(req_line), 104);
    step(0, 0, 0, 1, 0, 0);
    chk(!req_valid, "R2", "no fifth request", longint'(req_valid), 0);
    step(1, 1, 26'd101, 0, 0, 0);
    chk(pf_stall && !pf_hit, "R5", "head not filled", longint'(pf_stall), 1);
    step(0, 0, 0, 0, 1, 26'd103);
    step(1, 1, 26'd101, 0, 1, 26'd101);
    chk(pf_stall, "R5", "stall in fill cycle", longint'(pf_stall), 1);
    step(1, 1, 26'd101, 0, 0, 0);
    chk(pf_hit && pf_data == data_of(26'd101), "R7", "out-of-order fill hit", longint'(pf_hit), 1);
    step(0, 0, 0, 0, 0, 0);
    chk(req_valid && req_line == 26'd105, "R6", "refill request", longint'(req_line), 105);
    step(1, 0, 26'd102, 0, 0, 0);
    chk(!pf_hit && !pf_stall, "R9", "cache-hit lookup ignored", longint'(pf_hit), 0);
    step(1, 1, 26'd102, 0, 0, 0);
    chk(pf_stall, "R9", "head unchanged after ignored lookup", longint'(pf_stall), 1);
    step(0, 0, 0, 0, 1, 26'd102);
    step(1, 1, 26'd102, 0, 0, 0);
    chk(pf_hit, "R4", "head hit", longint'(pf_hit), 1);
    step(1, 1, 26'd104, 0, 0, 0);
    chk(!pf_hit && !pf_stall, "R10", "non-head match no hit", longint'(pf_hit), 0);
    step(0, 0, 0, 0, 1, 26'd105);
    chk(req_valid && req_line == 26'd105, "R10", "restart from non-head", longint'(req_line), 105);
    step(1, 1, 26'd105, 0, 0, 0);
    chk(pf_stall && !pf_hit, "R8", "stale fill dropped", longint'(pf_stall), 1);
    step(0, 0, 0, 0, 1, 26'd777);
    chk(!pf_hit, "R8", "unrelated fill no effect", longint'(pf_hit), 0);

    for (int c = 0; c < 4000; c++) begin
      lv = ($urandom % 2) == 0;
      lm = ($urandom % 4) != 0;
      case ($urandom % 8)
        0, 1, 2, 3, 4: l = mlive ? ml[0] : LINE_W'(300);
        5:             l = mlive ? ml[1] : LINE_W'(301);
        default:       l = LINE_W'(1000 + $urandom % 2000);
      endcase
      rr = ($urandom % 4) != 0 && npend < 60;
      fv = 0;
      if (npend > 0 && ($urandom % 2) == 0) begin
        int idx;
        idx = int'($urandom % npend);
        fv = 1;
        l = lv ? l : pend[idx];
        step(lv, lm, lv ? l : '0, rr, 1, pend[idx]);
      end else if (($urandom % 16) == 0) begin
        step(lv, lm, l, rr, 1, LINE_W'(5000 + $urandom % 100));
      end else begin
        step(lv, lm, l, rr, fv, '0);
      end
    end
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule